// File: doc/BRIEF.md
# Byte-Wide SPI Master with Serial-Port Style Status Logic

This block is a byte-oriented SPI master whose data path is organised the way a serial port's is. A one-deep holding buffer accepts a byte from the bus and hands it to an 8-bit shifter as soon as the shifter is idle. The shifter drives the serial clock and the outgoing data line, and samples the incoming data line. Each completed frame places the received byte into a one-deep receive buffer.

Software works through three bus-addressed registers. Address 0 is the data register: a write loads the holding buffer and a read returns the receive buffer. Address 1 is the status register. Address 2 is the control register, which holds three interrupt enables and separate enables for the receiver and the transmitter. A single interrupt request combines the three status flags with their enables and a global enable input. An acknowledge input clears the transmit-complete flag when its interrupt is serviced. The serial clock runs at a fixed division of the system clock, with its polarity idle low and data sampled on the rising edge.

Top module: `spim_top`

## Requirements
- R1: After reset, status (address 1) reads 0x20, control (address 2) reads 0x00, the interrupt output is low and the serial clock is low.
- R2: Writing address 0 while the holding buffer is empty loads it and clears status bit 5 (holding empty). When the shifter is idle and the transmitter is enabled, the byte moves into the shifter and bit 5 sets again. A write to address 0 while the holding buffer is full is ignored.
- R3: A frame is 8 bits, most significant bit first. The outgoing line changes only while the serial clock is low, the incoming line is sampled on each rising edge, and one serial clock period is 2*HALF_DIV system clocks.
- R4: With the receiver enabled (control bit 4), status bit 7 (receive complete) sets after the 8th sample and address 0 then returns the received byte. A read of address 0 with the read strobe high clears bit 7.
- R5: While control bit 4 is zero, status bit 7 reads zero. Unread data is flushed when the receiver is disabled, and frames shifted while it is disabled are not stored.
- R6: Status bit 6 (transmit complete) sets only when a frame ends and the holding buffer is empty. When a second byte is already waiting, the first frame's end does not set it.
- R7: Status bit 6 clears when a one is written to bit 6 of address 1, or when the acknowledge input pulses. Writing a zero to it has no effect.
- R8: Control bits 7, 6 and 5 are the receive-complete, transmit-complete and holding-empty interrupt enables, bit 4 enables the receiver and bit 3 enables the transmitter. Status bits 4..0 and control bits 2..0 read as zero, and writes to them are ignored.
- R9: The interrupt output is high exactly when the global enable input is high and at least one status flag among bits 7, 6 and 5 is set together with its enable.
- R10: With control bit 3 clear, no new frame starts and the serial clock stays low. A frame already in progress when the transmitter is disabled completes all 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the receive buffer at address 0) |
| bus_addr | input | 2 | Register address: 0 data, 1 status, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| gie | input | 1 | Global interrupt enable |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge pulse |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all 256 transmit bytes against a mode-0 slave model that returns a different byte for each one. A bit-order or sampling-edge fault therefore shows up as a corrupted byte on either line. Back-to-back frames catch a transmit-complete flag that sets at the end of the first frame even though a byte is still waiting. A receiver disabled after a frame catches a design that keeps stale data readable. Disabling the transmitter mid-frame catches both a shifter that truncates the frame and one that starts the next byte anyway. Writes to reserved bits, a zero write to the transmit-complete flag, and a write while the holding buffer is full each expose logic that latches bits it should drop.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        A_DATA = 2'd0,
        A_STAT = 2'd1,
        A_CTRL = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

    localparam int ST_RXC  = 7;
    localparam int ST_TXC  = 6;
    localparam int ST_HEMP = 5;
    localparam int CT_LSB  = 3;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
        logic he_ie;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] pack_ctrl(input ctrl_t c);
        return {c, {CT_LSB{1'b0}}};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic rxc, input logic txc, input logic hemp);
        return {rxc, txc, hemp, 5'b0};
    endfunction
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              frame_done
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_sh;
    logic [BC_W-1:0]   bit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            sck        <= 1'b0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            bit_idx    <= '0;
            rx_valid   <= 1'b0;
            rx_byte    <= '0;
            frame_done <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            frame_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sck     <= 1'b0;
                    tx_sh   <= load_byte;
                    bit_idx <= '0;
                end
            end else if (tick) begin
                if (!sck) begin
                    sck   <= 1'b1;
                    rx_sh <= {rx_sh[BYTE_W-2:0], miso};
                    if (bit_idx == LAST_BIT) begin
                        rx_valid <= 1'b1;
                        rx_byte  <= {rx_sh[BYTE_W-2:0], miso};
                    end
                end else begin
                    sck <= 1'b0;
                    if (bit_idx == LAST_BIT) begin
                        busy       <= 1'b0;
                        frame_done <= 1'b1;
                    end else begin
                        tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi = tx_sh[BYTE_W-1];
endmodule

// File: rtl/spim_regs.sv
module spim_regs
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              gie,
    input  logic              txc_ack,
    input  logic              busy,
    input  logic              frame_done,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              start,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              hold_full,
    output logic              tx_done,
    output logic              rx_full,
    output ctrl_t             ctrl,
    output logic              irq
);
    reg_addr_e         sel;
    logic [BYTE_W-1:0] rx_buf;
    logic              wr_data, wr_stat, wr_ctrl, pop;

    assign sel     = reg_addr_e'(addr);
    assign wr_data = wr && (sel == A_DATA);
    assign wr_stat = wr && (sel == A_STAT);
    assign wr_ctrl = wr && (sel == A_CTRL);
    assign pop     = rd && (sel == A_DATA);
    assign start   = hold_full && !busy && ctrl.tx_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            tx_byte   <= '0;
            hold_full <= 1'b0;
            tx_done   <= 1'b0;
            rx_full   <= 1'b0;
            rx_buf    <= '0;
        end else begin
            if (wr_ctrl) ctrl <= ctrl_t'(wdata[BYTE_W-1:CT_LSB]);

            if (start) begin
                hold_full <= 1'b0;
            end else if (wr_data && !hold_full) begin
                tx_byte   <= wdata;
                hold_full <= 1'b1;
            end

            if (frame_done && !hold_full)               tx_done <= 1'b1;
            else if (txc_ack || (wr_stat && wdata[ST_TXC])) tx_done <= 1'b0;

            if (!ctrl.rx_en) begin
                rx_full <= 1'b0;
            end else if (rx_valid) begin
                rx_buf  <= rx_byte;
                rx_full <= 1'b1;
            end else if (pop) begin
                rx_full <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (sel)
            A_DATA:  rdata = rx_buf;
            A_STAT:  rdata = pack_status(rx_full, tx_done, !hold_full);
            A_CTRL:  rdata = pack_ctrl(ctrl);
            default: rdata = '0;
        endcase
    end

    assign irq = gie && ((ctrl.rx_ie && rx_full) ||
                         (ctrl.tx_ie && tx_done) ||
                         (ctrl.he_ie && !hold_full));
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        gie,
    input  logic        txc_ack,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        irq
);
    logic              shift_busy, baud_tick, start, frame_done, rx_valid;
    logic              hold_full, tx_done, rx_full;
    logic [BYTE_W-1:0] tx_byte, rx_byte;
    ctrl_t             ctrl;

    spim_baud #(.HALF_DIV(HALF_DIV)) u_baud (
        .clk (clk),
        .rst (rst),
        .run (shift_busy),
        .tick(baud_tick)
    );

    spim_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .start     (start),
        .load_byte (tx_byte),
        .miso      (spi_miso),
        .busy      (shift_busy),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .frame_done(frame_done)
    );

    spim_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .gie       (gie),
        .txc_ack   (txc_ack),
        .busy      (shift_busy),
        .frame_done(frame_done),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .start     (start),
        .tx_byte   (tx_byte),
        .hold_full (hold_full),
        .tx_done   (tx_done),
        .rx_full   (rx_full),
        .ctrl      (ctrl),
        .irq       (irq)
    );
endmodule

// File: rtl/spim_chk.sv
module spim_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic sck,
    input logic hold_full,
    input logic tx_done,
    input logic frame_done,
    input logic rx_full,
    input logic rx_en,
    input logic tx_en,
    input logic gie,
    input logic irq
);
    // R3
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !sck);

    // R2
    hold_handoff_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !hold_full);

    // R5
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst) !rx_en |=> !rx_full);

    // R6
    txc_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> ($past(frame_done) && !$past(hold_full)));

    // R10
    tx_gate_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(tx_en));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst) !gie |-> !irq);
endmodule

bind spim_top spim_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (shift_busy),
    .sck       (spi_sck),
    .hold_full (hold_full),
    .tx_done   (tx_done),
    .frame_done(frame_done),
    .rx_full   (rx_full),
    .rx_en     (ctrl.rx_en),
    .tx_en     (ctrl.tx_en),
    .gie       (gie),
    .irq       (irq)
);

// File: tb/tb_spim_top.sv
module tb_spim_top;
    localparam int HD = 2;
    localparam logic [1:0] AD = 2'd0, AS = 2'd1, AC = 2'd2;
    localparam logic [7:0] EN_BOTH = 8'h18;

    logic clk = 1'b0, rst = 1'b1;
    logic bus_wr = 0, bus_rd = 0, gie = 0, txc_ack = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic spi_sck, spi_mosi, spi_miso, irq;

    int n_cmp = 0, n_bad = 0, cyc = 0, n_rise = 0;
    logic [7:0]  mosi_cap = 0;
    logic [15:0] slave_sh = 0;

    always #2 clk = ~clk;

    spim_top #(.HALF_DIV(HD)) dut (.*);

    assign spi_miso = slave_sh[15];
    always @(posedge spi_sck) begin
        mosi_cap <= {mosi_cap[6:0], spi_mosi};
        n_rise   <= n_rise + 1;
    end
    always @(negedge spi_sck) slave_sh <= {slave_sh[14:0], 1'b0};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired actual %0d expected <150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0;
    endtask

    task automatic poll(input int b, input logic v, input string tag);
        logic [7:0] d = 0;
        for (int k = 0; k < 3000; k++) begin
            rd(AS, d);
            if (d[b] == v) break;
        end
        check(tag, 16'(d[b]), 16'(v));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] d;
        int base;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(AS, d); check("R1 status", 16'(d), 16'h20);
        rd(AC, d); check("R1 control", 16'(d), 16'h00);
        check("R1 irq", 16'(irq), 0);
        check("R1 sck", 16'(spi_sck), 0);

        // R8 layout and reserved bits
        wr(AC, 8'hFF); rd(AC, d); check("R8 ctrl readback", 16'(d), 16'hF8);
        wr(AC, EN_BOTH);
        wr(AS, 8'h1F); rd(AS, d); check("R8 status reserved", 16'(d), 16'h20);

        // R3 R4 full sweep
        for (int i = 0; i < 256; i++) begin
            logic [7:0] sb;
            sb = 8'(i) ^ 8'hA5 ^ 8'(i << 3);
            slave_sh = {sb, 8'h00};
            wr(AD, 8'(i));
            poll(6, 1'b1, "R6 txc after frame");
            rd(AS, d); check("R4 rxc set", 16'(d[7]), 1);
            rd(AD, d); check("R4 rx byte", 16'(d), 16'(sb));
            check("R3 mosi byte", 16'(mosi_cap), 16'(i));
            rd(AS, d); check("R4 rxc cleared by read", 16'(d[7]), 0);
            wr(AS, 8'h00); rd(AS, d); check("R7 zero write keeps", 16'(d[6]), 1);
            wr(AS, 8'h40); rd(AS, d); check("R7 one write clears", 16'(d[6]), 0);
        end

        // R3 serial clock period
        slave_sh = 0;
        wr(AD, 8'h81);
        begin
            time t1, t2;
            @(posedge spi_sck); t1 = $time;
            @(posedge spi_sck); t2 = $time;
            check("R3 sck period", 16'(t2 - t1), 16'(2 * HD * 4));
        end
        poll(6, 1'b1, "R6 txc period frame");
        // R7 acknowledge clears
        @(negedge clk); txc_ack = 1; @(negedge clk); txc_ack = 0;
        rd(AS, d); check("R7 ack clears", 16'(d[6]), 0);

        // R6 back-to-back: flag only after second frame
        slave_sh = 16'h3CC3;
        base = n_rise;
        wr(AD, 8'h5A);
        poll(5, 1'b1, "R2 hold empty after handoff");
        wr(AD, 8'hC6);
        poll(6, 1'b1, "R6 txc after pair");
        check("R6 rises before txc", 16'(n_rise - base), 16);
        check("R6 second byte out", 16'(mosi_cap), 16'hC6);
        rd(AD, d); check("R4 second rx byte", 16'(d), 16'hC3);
        wr(AS, 8'h40);

        // R2 write while full ignored, R10 disabled transmitter holds
        wr(AC, 8'h10);
        base = n_rise;
        wr(AD, 8'h11);
        wr(AD, 8'h22);
        rd(AS, d); check("R2 hold full flag", 16'(d[5]), 0);
        idle(100);
        check("R10 no frame while off", 16'(n_rise - base), 0);
        check("R10 sck low while off", 16'(spi_sck), 0);
        wr(AC, EN_BOTH);
        poll(6, 1'b1, "R10 frame after enable");
        check("R2 first byte kept", 16'(mosi_cap), 16'h11);
        wr(AS, 8'h40);

        // R10 in-progress frame completes after disable
        base = n_rise;
        wr(AD, 8'h96);
        while (n_rise - base < 2) @(negedge clk);
        wr(AC, 8'h10);
        idle(150);
        check("R10 frame completes", 16'(n_rise - base), 8);
        check("R10 byte completes", 16'(mosi_cap), 16'h96);
        check("R10 sck idle", 16'(spi_sck), 0);

        // R5 flush on receiver disable
        wr(AC, EN_BOTH);
        slave_sh = 16'hE700;
        wr(AD, 8'h01);
        poll(6, 1'b1, "R5 frame done");
        rd(AS, d); check("R5 rxc before flush", 16'(d[7]), 1);
        wr(AC, 8'h08);
        rd(AS, d); check("R5 flushed", 16'(d[7]), 0);
        wr(AC, EN_BOTH);
        rd(AS, d); check("R5 stays flushed", 16'(d[7]), 0);
        wr(AC, 8'h08);
        wr(AS, 8'h40);
        wr(AD, 8'h02);
        poll(6, 1'b1, "R5 frame while rx off");
        wr(AC, EN_BOTH);
        rd(AS, d); check("R5 not stored while off", 16'(d[7]), 0);

        // R9 interrupt gating
        slave_sh = 16'h4400;
        wr(AS, 8'h40);
        wr(AD, 8'h03);
        poll(6, 1'b1, "R9 frame");
        wr(AC, EN_BOTH | 8'h80);
        gie = 0; #1 check("R9 gie low", 16'(irq), 0);
        @(negedge clk); gie = 1; #1 check("R9 rx source", 16'(irq), 1);
        rd(AD, d); #1 check("R9 rx source gone", 16'(irq), 0);
        wr(AC, EN_BOTH | 8'h20); #1 check("R9 empty source", 16'(irq), 1);
        wr(AC, EN_BOTH | 8'h40); #1 check("R9 tx source", 16'(irq), 1);
        @(negedge clk); txc_ack = 1; @(negedge clk); txc_ack = 0;
        #1 check("R9 tx source acked", 16'(irq), 0);
        gie = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule